// File: doc/BRIEF.md
# ISA Option-Memory Window Decoder

This block sits on the 8-bit ISA side of an expansion card and produces the chip enable for a socketed boot-memory device, either a ROM or a static RAM. Software programs the window through a small bank of I/O registers inside a 32-byte I/O block. The window can be 16 KB, 32 KB or 64 KB in size, or it can be switched off. Its base is set in 16 KB steps, and it always lies in the upper half of the 1 MB memory space.

The I/O block has two live offsets. Offset 1 holds a control byte. Bit 1 of that byte is a bank selector that decides which of two registers answers at offset 3. With the selector clear, offset 3 holds the window register. With it set, offset 3 holds the mode register, and bit 3 of the mode register turns on RAM mode. Memory reads inside the window always enable the socket. Memory writes inside the window enable it only while RAM mode is on. A hardware reset clears every register. A soft reset leaves the mode register untouched, so RAM mode survives it.

Top module: `optmem_window_dec`

## Requirements
- R1: An I/O cycle hits the block only when AEN is low and SA[9:5] equals bits 9:5 of the IO_BASE parameter (default 0x260). A read that hits drives dout_oe high, and a read that misses leaves dout_oe low.
- R2: A write to offset 1 stores the whole byte in the control register, and a read of offset 1 returns that byte.
- R3: When control bit 1 is 0, offset 3 reads and writes the window register. Its bits 7:6 are the size code, bits 5:1 are matched against SA18..SA14, and bit 0 is stored but has no effect on decoding.
- R4: When control bit 1 is 1, offset 3 reads and writes the mode register. A write to either register behind offset 3 leaves the other one unchanged.
- R5: A size code of 00 keeps mem_ce_n high for every address and every strobe.
- R6: Size codes 01, 10 and 11 select a 16 KB, 32 KB or 64 KB window. The window starts at 0x80000 + 16K × bits 5:1 of the window register, rounded down to a multiple of the window size. SA19 must be 1 for an address to fall inside the window.
- R7: mem_ce_n goes low in the same cycle that MEMR# is low, AEN is low and SA falls inside the window.
- R8: With MEMW# low, AEN low and SA inside the window, mem_ce_n goes low only while bit 3 of the mode register is 1. While that bit is 0, writes never enable the socket.
- R9: While AEN is high, mem_ce_n stays high, dout_oe stays low and I/O writes change no register.
- R10: A cold reset (cold_rst_n low) clears all three registers. A warm reset (warm_rst_n low) clears the control and window registers but keeps the mode register.
- R11: A read of any offset in the block other than 1 and 3 returns 0x00 with dout_oe high.

Top module ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| cold_rst_n | input | 1 | Cold reset, active low, clears all registers |
| warm_rst_n | input | 1 | Soft reset, active low, keeps the mode register |
| sa | input | 20 | ISA system address |
| aen | input | 1 | DMA address enable, high during DMA |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| memr_n | input | 1 | Memory read strobe, active low |
| memw_n | input | 1 | Memory write strobe, active low |
| din | input | 8 | Write data from the bus |
| dout | output | 8 | Read data for the bus |
| dout_oe | output | 1 | Read data drive enable |
| mem_ce_n | output | 1 | Memory socket chip enable, active low |

## Verification
All 256 window register values are swept against every 16 KB step of the 1 MB space. The expected hit is computed from a base and span in byte arithmetic, so the sweep separates the three sizes and checks that SA14 and SA15 are ignored in the larger windows. It also covers the SA19 rule and the disabled code. At each point the bench applies a memory read, a memory write and a DMA-qualified read. The whole sweep runs once with RAM mode off and once with it on, which separates the read path from the write gating. Directed sequences cover bank switching, register isolation, the unused offsets, out-of-block decoding, and the different effects of the two resets.

// File: rtl/optmem_pkg.sv
package optmem_pkg;
  localparam int ADDR_W    = 20;
  localparam int IO_AW     = 10;
  localparam int IO_BLK_W  = 5;
  localparam int WIN_SEL_W = 5;
  localparam int WIN_LSB   = 14;
  localparam int CFG_W     = 8;

  localparam logic [IO_BLK_W-1:0] OFF_CTRL  = 5'd1;
  localparam logic [IO_BLK_W-1:0] OFF_PAGED = 5'd3;
  localparam int BANK_BIT = 1;
  localparam int RAM_BIT  = 3;

  typedef enum logic [1:0] {
    WIN_OFF = 2'b00,
    WIN_16K = 2'b01,
    WIN_32K = 2'b10,
    WIN_64K = 2'b11
  } win_size_e;

  // Which of SA18..SA14 take part in the compare for a given size.
  function automatic logic [WIN_SEL_W-1:0] win_mask(win_size_e s);
    case (s)
      WIN_16K: return 5'b11111;
      WIN_32K: return 5'b11110;
      WIN_64K: return 5'b11100;
      default: return 5'b00000;
    endcase
  endfunction
endpackage

// File: rtl/optmem_io_decode.sv
module optmem_io_decode
  import optmem_pkg::*;
#(
  parameter logic [IO_AW-1:0] IO_BASE = 10'h260
) (
  input  logic [IO_AW-1:0]    io_addr,
  input  logic                aen,
  output logic                io_hit,
  output logic [IO_BLK_W-1:0] io_off
);
  localparam int TAG_W = IO_AW - IO_BLK_W;
  localparam logic [TAG_W-1:0] BASE_TAG = IO_BASE[IO_AW-1:IO_BLK_W];

  always_comb begin
    io_hit = !aen && (io_addr[IO_AW-1:IO_BLK_W] == BASE_TAG);
    io_off = io_addr[IO_BLK_W-1:0];
  end
endmodule

// File: rtl/optmem_cfg_regs.sv
module optmem_cfg_regs
  import optmem_pkg::*;
(
  input  logic             clk,
  input  logic             cold_rst_n,
  input  logic             warm_rst_n,
  input  logic             wr_ctrl,
  input  logic             wr_paged,
  input  logic [CFG_W-1:0] din,
  output logic [CFG_W-1:0] ctrl_q,
  output logic [CFG_W-1:0] win_q,
  output logic [CFG_W-1:0] ee_q
);
  logic bank_hi;
  assign bank_hi = ctrl_q[BANK_BIT];

  // Control and window registers: cleared by either reset.
  always_ff @(posedge clk) begin
    if (!cold_rst_n || !warm_rst_n) begin
      ctrl_q <= '0;
      win_q  <= '0;
    end else begin
      if (wr_ctrl)              ctrl_q <= din;
      if (wr_paged && !bank_hi) win_q  <= din;
    end
  end

  // Mode register: only a cold reset clears it.
  always_ff @(posedge clk) begin
    if (!cold_rst_n)
      ee_q <= '0;
    else if (warm_rst_n && wr_paged && bank_hi)
      ee_q <= din;
  end
endmodule

// File: rtl/optmem_mem_window.sv
module optmem_mem_window
  import optmem_pkg::*;
(
  input  logic [ADDR_W-1:0] sa,
  input  logic              aen,
  input  logic              memr_n,
  input  logic              memw_n,
  input  logic [CFG_W-1:1]  win_cfg,
  input  logic              ram_en,
  output logic              win_hit,
  output logic              ce_n
);
  win_size_e              size;
  logic [WIN_SEL_W-1:0]   mask;
  logic [WIN_SEL_W-1:0]   bit_ok;
  logic                   rd_sel;
  logic                   wr_sel;

  assign size = win_size_e'(win_cfg[CFG_W-1:CFG_W-2]);
  assign mask = win_mask(size);

  for (genvar i = 0; i < WIN_SEL_W; i++) begin : g_cmp
    assign bit_ok[i] = !mask[i] || (sa[WIN_LSB+i] == win_cfg[1+i]);
  end

  always_comb begin
    win_hit = (size != WIN_OFF) && sa[ADDR_W-1] && (&bit_ok);
    rd_sel  = !aen && !memr_n && win_hit;
    wr_sel  = !aen && !memw_n && ram_en && win_hit;
    ce_n    = !(rd_sel || wr_sel);
  end
endmodule

// File: rtl/optmem_window_dec.sv
module optmem_window_dec
  import optmem_pkg::*;
#(
  parameter logic [9:0] IO_BASE = 10'h260
) (
  input  logic        clk,
  input  logic        cold_rst_n,
  input  logic        warm_rst_n,
  input  logic [19:0] sa,
  input  logic        aen,
  input  logic        ior_n,
  input  logic        iow_n,
  input  logic        memr_n,
  input  logic        memw_n,
  input  logic [7:0]  din,
  output logic [7:0]  dout,
  output logic        dout_oe,
  output logic        mem_ce_n
);
  logic                io_hit;
  logic [IO_BLK_W-1:0] io_off;
  logic                wr_ctrl;
  logic                wr_paged;
  logic [CFG_W-1:0]    ctrl_q;
  logic [CFG_W-1:0]    win_q;
  logic [CFG_W-1:0]    ee_q;
  logic                ram_mode;
  logic                win_hit;
  logic [CFG_W-1:0]    rd_mux;

  optmem_io_decode #(.IO_BASE(IO_BASE)) u_io (
    .io_addr (sa[IO_AW-1:0]),
    .aen     (aen),
    .io_hit  (io_hit),
    .io_off  (io_off)
  );

  assign wr_ctrl  = io_hit && !iow_n && (io_off == OFF_CTRL);
  assign wr_paged = io_hit && !iow_n && (io_off == OFF_PAGED);

  optmem_cfg_regs u_regs (
    .clk        (clk),
    .cold_rst_n (cold_rst_n),
    .warm_rst_n (warm_rst_n),
    .wr_ctrl    (wr_ctrl),
    .wr_paged   (wr_paged),
    .din        (din),
    .ctrl_q     (ctrl_q),
    .win_q      (win_q),
    .ee_q       (ee_q)
  );

  assign ram_mode = ee_q[RAM_BIT];

  optmem_mem_window u_win (
    .sa      (sa),
    .aen     (aen),
    .memr_n  (memr_n),
    .memw_n  (memw_n),
    .win_cfg (win_q[CFG_W-1:1]),
    .ram_en  (ram_mode),
    .win_hit (win_hit),
    .ce_n    (mem_ce_n)
  );

  always_comb begin
    case (io_off)
      OFF_CTRL:  rd_mux = ctrl_q;
      OFF_PAGED: rd_mux = ctrl_q[BANK_BIT] ? ee_q : win_q;
      default:   rd_mux = '0;
    endcase
    dout_oe = io_hit && !ior_n;
    dout    = dout_oe ? rd_mux : '0;
  end
endmodule

// File: rtl/optmem_window_dec_chk.sv
module optmem_window_dec_chk (
  input logic        clk,
  input logic        cold_rst_n,
  input logic        warm_rst_n,
  input logic [19:0] sa,
  input logic        aen,
  input logic        memr_n,
  input logic        memw_n,
  input logic [7:0]  din,
  input logic        mem_ce_n,
  input logic        dout_oe,
  input logic        ram_mode,
  input logic [1:0]  win_size,
  input logic        wr_ctrl,
  input logic [7:0]  ctrl_q,
  input logic [7:0]  ee_q
);
  // R9
  aen_block_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    aen |-> (mem_ce_n && !dout_oe));

  // R8
  write_gate_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (memr_n && !memw_n && !ram_mode) |-> mem_ce_n);

  // R5
  size_off_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (win_size == 2'b00) |-> mem_ce_n);

  // R6
  upper_half_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !sa[19] |-> mem_ce_n);

  // R2
  ctrl_store_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (wr_ctrl && warm_rst_n) |=> (ctrl_q == $past(din)));

  // R10
  warm_keep_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !warm_rst_n |=> (ee_q == $past(ee_q)));
endmodule

bind optmem_window_dec optmem_window_dec_chk u_chk (
  .clk        (clk),
  .cold_rst_n (cold_rst_n),
  .warm_rst_n (warm_rst_n),
  .sa         (sa),
  .aen        (aen),
  .memr_n     (memr_n),
  .memw_n     (memw_n),
  .din        (din),
  .mem_ce_n   (mem_ce_n),
  .dout_oe    (dout_oe),
  .ram_mode   (ram_mode),
  .win_size   (win_q[7:6]),
  .wr_ctrl    (wr_ctrl),
  .ctrl_q     (ctrl_q),
  .ee_q       (ee_q)
);

// File: tb/test_optmem_window_dec.sv
`timescale 1ns/1ps
module test_optmem_window_dec;
  logic        clk = 1'b0;
  logic        cold_rst_n = 1'b0;
  logic        warm_rst_n = 1'b1;
  logic [19:0] sa = '0;
  logic        aen = 1'b0;
  logic        ior_n = 1'b1;
  logic        iow_n = 1'b1;
  logic        memr_n = 1'b1;
  logic        memw_n = 1'b1;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        dout_oe;
  logic        mem_ce_n;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  optmem_window_dec i_optmem_window_dec (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n), .sa(sa),
    .aen(aen), .ior_n(ior_n), .iow_n(iow_n), .memr_n(memr_n), .memw_n(memw_n),
    .din(din), .dout(dout), .dout_oe(dout_oe), .mem_ce_n(mem_ce_n)
  );

  localparam logic [19:0] IOB = 20'h260;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic io_wr(input logic [19:0] a, input logic [7:0] d, input logic dma = 1'b0);
    @(negedge clk);
    sa = a; din = d; aen = dma; iow_n = 1'b0;
    @(negedge clk);
    iow_n = 1'b1; aen = 1'b0;
  endtask

  task automatic io_rd(input logic [19:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    sa = a; ior_n = 1'b0;
    #2;
    d = dout; oe = dout_oe;
    ior_n = 1'b1;
  endtask

  // Window hit from byte arithmetic: base and span, aligned down.
  function automatic bit exp_hit(logic [7:0] w, logic [19:0] a);
    int span, base;
    if (w[7:6] == 2'b00) return 1'b0;
    span = 16384 << (int'(w[7:6]) - 1);
    base = 'h80000 + int'(w[5:1]) * 16384;
    base = base - (base % span);
    return (int'(a) >= base) && (int'(a) < base + span);
  endfunction

  task automatic mem_probe(input logic [19:0] a, input bit rd, input bit dma, output logic ce);
    sa = a; aen = dma;
    if (rd) memr_n = 1'b0; else memw_n = 1'b0;
    #1;
    ce = mem_ce_n;
    memr_n = 1'b1; memw_n = 1'b1; aen = 1'b0;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired act=hung exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic oe, ce;
    repeat (3) @(negedge clk);
    cold_rst_n = 1'b1;

    // Reset state
    io_rd(IOB + 1, d, oe); chk("R10 cold ctrl", d, 0); chk("R1 read oe", oe, 1);
    io_rd(IOB + 3, d, oe); chk("R10 cold window", d, 0);
    mem_probe(20'hD8000, 1, 0, ce); chk("R5 off after reset", ce, 1);
    io_wr(IOB + 1, 8'h02);
    io_rd(IOB + 3, d, oe); chk("R10 cold mode", d, 0);
    io_wr(IOB + 1, 8'h00);

    // Decode and unused offsets
    io_rd(IOB + 5, d, oe); chk("R11 offset5 data", d, 0); chk("R11 offset5 oe", oe, 1);
    io_rd(IOB + 31, d, oe); chk("R11 offset31 oe", oe, 1);
    io_rd(20'h280, d, oe); chk("R1 above block oe", oe, 0);
    io_rd(20'h240, d, oe); chk("R1 below block oe", oe, 0);
    io_wr(20'h281, 8'h55);
    io_rd(IOB + 1, d, oe); chk("R1 alias write ignored", d, 0);
    io_wr(IOB + 1, 8'hF5);
    io_rd(IOB + 1, d, oe); chk("R2 ctrl readback", d, 8'hF5);
    io_wr(IOB + 1, 8'h00);
    io_wr(IOB + 1, 8'h3C, 1'b1);
    io_rd(IOB + 1, d, oe); chk("R9 dma write ignored", d, 0);

    // Bank isolation
    io_wr(IOB + 3, 8'hAC);
    io_wr(IOB + 1, 8'h02);
    io_wr(IOB + 3, 8'h5A);
    io_rd(IOB + 3, d, oe); chk("R4 mode readback", d, 8'h5A);
    io_wr(IOB + 1, 8'h00);
    io_rd(IOB + 3, d, oe); chk("R4 window kept", d, 8'hAC);
    mem_probe(20'hDC000, 1, 0, ce); chk("R6 example inside", ce, 0);
    mem_probe(20'hD4000, 1, 0, ce); chk("R6 example below", ce, 1);
    mem_probe(20'hE0000, 1, 0, ce); chk("R6 example above", ce, 1);

    // Exhaustive sweep: ram mode off then on
    for (int ram = 0; ram < 2; ram++) begin
      io_wr(IOB + 1, 8'h02);
      io_wr(IOB + 3, ram ? 8'h08 : 8'hF7);
      io_wr(IOB + 1, 8'h00);
      for (int w = 0; w < 256; w++) begin
        io_wr(IOB + 3, 8'(w));
        io_rd(IOB + 3, d, oe); chk("R3 window readback", d, w);
        for (int s = 0; s < 64; s++) begin
          logic [19:0] a;
          bit h;
          a = {6'(s), 14'h1A5};
          h = exp_hit(8'(w), a);
          mem_probe(a, 1, 0, ce); chk("R7 read enable", ce, h ? 0 : 1);
          mem_probe(a, 0, 0, ce); chk("R8 write enable", ce, (h && ram) ? 0 : 1);
          mem_probe(a, 1, 1, ce); chk("R9 dma read blocked", ce, 1);
        end
      end
    end

    // Warm vs cold reset
    io_wr(IOB + 3, 8'hAC);
    io_wr(IOB + 1, 8'h02);
    io_wr(IOB + 3, 8'h08);
    @(negedge clk); warm_rst_n = 1'b0;
    @(negedge clk); warm_rst_n = 1'b1;
    io_rd(IOB + 1, d, oe); chk("R10 warm clears ctrl", d, 0);
    io_rd(IOB + 3, d, oe); chk("R10 warm clears window", d, 0);
    io_wr(IOB + 1, 8'h02);
    io_rd(IOB + 3, d, oe); chk("R10 warm keeps mode", d, 8'h08);
    @(negedge clk); cold_rst_n = 1'b0;
    @(negedge clk); cold_rst_n = 1'b1;
    io_wr(IOB + 1, 8'h02);
    io_rd(IOB + 3, d, oe); chk("R10 cold clears mode", d, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule